// File: doc/BRIEF.md
# Byte/Word Load Address Unit

This block turns one load request into a memory read and a base-register update. It adds or subtracts an offset to the base. It then chooses which address drives the memory: the base itself or the adjusted value. It also decides whether the adjusted value goes back to the base register. The offset comes from one of three sources: an immediate field, an index register, or an index register shifted left by a small amount.

The read goes to a synchronous memory port with one cycle of latency. That port returns a full 32-bit word. One cycle after the request, the block returns one of two results: the whole word, or one byte of it. A byte is extended to 32 bits with either zeros or copies of its top bit. The same cycle carries the writeback enable and the new base value.

The byte order within a word is either little-endian or big-endian. It is fixed while the block is held in reset and stays fixed after that.

Top module: `load_addr_unit`

## Requirements
- R1: With `addr_mode` 0 (plain offset, and the unused code 3 behaves the same), `mem_addr` is the word address of base±offset, and `wb_en` stays 0 in the result cycle.
- R2: With `addr_mode` 1 (pre-indexed), `mem_addr` is the word address of base±offset. In the result cycle `wb_en` is 1 and `wb_base` equals base±offset.
- R3: With `addr_mode` 2 (post-indexed), `mem_addr` is the word address of the unmodified base. In the result cycle `wb_en` is 1 and `wb_base` equals base±offset.
- R4: `off_sel` chooses the offset: 0 gives `imm_off` zero-extended, 1 gives `idx_val`, and 2 or 3 give `idx_val` shifted left by `shift_amt` (0 to 3).
- R5: When `sub_off` is 1 the offset is subtracted from the base; when it is 0 the offset is added.
- R6: `mem_rd_en` equals `req_valid` in the same cycle, and `mem_addr` always has bits 1:0 equal to zero. `result_valid`, `result_data`, `wb_en` and `wb_base` belong to the cycle after the request. In a cycle that follows no request, `result_valid` and `wb_en` are 0.
- R7: An unsigned byte load (`size_byte`=1, `sign_ext`=0) returns the chosen byte in bits 7:0 with bits 31:8 cleared.
- R8: A signed byte load (`size_byte`=1, `sign_ext`=1) returns the chosen byte in bits 7:0 with bits 31:8 all equal to bit 7 of that byte.
- R9: In little-endian order, the byte at address offset k within a word comes from `mem_rdata` bits 8k+7:8k. A word load (`size_byte`=0) returns `mem_rdata` unchanged and ignores address bits 1:0.
- R10: In big-endian order, the byte at address offset k comes from `mem_rdata` bits 8(3-k)+7:8(3-k).
- R11: `big_endian_sel` is sampled only on clock edges while `rst_n` is 0. Changing it after reset has no effect on which byte is returned.
- R12: While `rst_n` is 0, `result_valid` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| big_endian_sel | input | 1 | Byte order select, captured during reset |
| req_valid | input | 1 | Load request this cycle |
| base_val | input | ADDR_W | Base register value |
| imm_off | input | IMM_W | Immediate offset |
| idx_val | input | ADDR_W | Index register value |
| off_sel | input | 2 | Offset source select |
| shift_amt | input | 2 | Left shift applied to the index |
| sub_off | input | 1 | 1 subtracts the offset from the base |
| addr_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| size_byte | input | 1 | 1 byte load, 0 word load |
| sign_ext | input | 1 | 1 sign-extends a byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_rdata | input | 32 | Read data, one cycle after the strobe |
| result_valid | output | 1 | Load result present |
| result_data | output | 32 | Loaded value |
| wb_en | output | 1 | Base register writeback enable |
| wb_base | output | ADDR_W | New base value |

## Verification
The assertions assume a memory that answers every read strobe exactly one cycle later. They also assume that the request fields stay stable during the request cycle, so that the data-extension checks can relate the result to the request of the cycle before. The bench models that memory itself: it returns a word computed from the address, and its byte values have both set and clear top bits. Requests are held for one full cycle from a falling edge, and the mode code 3 is exercised only as an alias of plain offset.

// File: rtl/load_addr_unit.sv
module load_addr_unit #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_sel,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [1:0]        off_sel,
  input  logic [1:0]        shift_amt,
  input  logic              sub_off,
  input  logic [1:0]        addr_mode,
  input  logic              size_byte,
  input  logic              sign_ext,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              result_valid,
  output logic [31:0]       result_data,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_base
);
  localparam logic [1:0] MODE_PRE  = 2'd1;
  localparam logic [1:0] MODE_POST = 2'd2;
  localparam int PAD_W = ADDR_W - IMM_W;

  logic              be_q;
  logic [ADDR_W-1:0] off_val, sum_val, acc_addr;
  logic              vld_q, byte_q, sext_q, wb_q;
  logic [1:0]        lane_q;
  logic [ADDR_W-1:0] wbb_q;
  logic [7:0]        sel_byte;

  always_comb begin
    case (off_sel)
      2'd0:    off_val = {{PAD_W{1'b0}}, imm_off};
      2'd1:    off_val = idx_val;
      default: off_val = idx_val << shift_amt;
    endcase
  end

  assign sum_val   = sub_off ? base_val - off_val : base_val + off_val;
  assign acc_addr  = (addr_mode == MODE_POST) ? base_val : sum_val;
  assign mem_rd_en = req_valid;
  assign mem_addr  = {acc_addr[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_q   <= big_endian_sel;
      vld_q  <= 1'b0;
      wb_q   <= 1'b0;
      lane_q <= 2'd0;
      byte_q <= 1'b0;
      sext_q <= 1'b0;
      wbb_q  <= '0;
    end else begin
      vld_q  <= req_valid;
      wb_q   <= req_valid && (addr_mode == MODE_PRE || addr_mode == MODE_POST);
      lane_q <= acc_addr[1:0] ^ {2{be_q}};
      byte_q <= size_byte;
      sext_q <= sign_ext;
      wbb_q  <= sum_val;
    end
  end

  assign sel_byte     = mem_rdata[8*lane_q +: 8];
  assign result_data  = byte_q ? {{24{sext_q & sel_byte[7]}}, sel_byte} : mem_rdata;
  assign result_valid = vld_q;
  assign wb_en        = vld_q & wb_q;
  assign wb_base      = wbb_q;

  // R6: result follows each request one cycle later
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> result_valid);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !result_valid && !wb_en);
  p_offset_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (addr_mode == 2'd0 || addr_mode == 2'd3) |=> !wb_en);
  p_pre_wb_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && addr_mode == MODE_PRE |=>
      wb_en && wb_base[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2]));
  p_post_base_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && addr_mode == MODE_POST |-> mem_addr[ADDR_W-1:2] == base_val[ADDR_W-1:2]);
  p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && size_byte && !sign_ext |=> result_data[31:8] == 24'd0);
  p_sign_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && size_byte && sign_ext |=> result_data[31:8] == {24{result_data[7]}});
  p_word_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !size_byte |=> result_data == mem_rdata);
endmodule

// File: tb/load_addr_unit_test.sv
module load_addr_unit_test;
  localparam int AW = 32;
  localparam int IW = 12;

  logic clk = 0, rst_n = 0, big_endian_sel = 0, req_valid = 0;
  logic [AW-1:0] base_val = 0, idx_val = 0;
  logic [IW-1:0] imm_off = 0;
  logic [1:0] off_sel = 0, shift_amt = 0, addr_mode = 0;
  logic sub_off = 0, size_byte = 0, sign_ext = 0;
  logic mem_rd_en, result_valid, wb_en;
  logic [AW-1:0] mem_addr, wb_base;
  logic [31:0] mem_rdata = 0, result_data;

  int errors = 0, checks = 0;
  bit exp_be = 0;

  typedef struct { logic [31:0] data; logic wb; logic [AW-1:0] wbase; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  load_addr_unit #(.ADDR_W(AW), .IMM_W(IW)) uut (.*);

  function automatic logic [31:0] mem_word(logic [AW-1:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = {a[7:2], 2'(k)} ^ 8'hC6;
    return w;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

  task automatic chk(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(result_valid === 1'b1, {e.tag, " R6 valid"}, AW'(result_valid), 1);
        chk(result_data === e.data, {e.tag, " data"}, result_data, e.data);
        chk(wb_en === e.wb, {e.tag, " wb_en"}, AW'(wb_en), AW'(e.wb));
        if (e.wb) chk(wb_base === e.wbase, {e.tag, " wb_base"}, wb_base, e.wbase);
      end else if (result_valid !== 1'b0 || wb_en !== 1'b0)
        chk(0, "R6 idle result", AW'(result_valid), 0);
    end
  end

  task automatic load(logic [AW-1:0] b, logic [IW-1:0] im, logic [AW-1:0] ix,
                      logic [1:0] os, logic [1:0] sh, bit sb_, logic [1:0] md,
                      bit by, bit sg, string tag);
    logic [AW-1:0] off, sum, acc;
    logic [31:0] w, d;
    logic [7:0] bt;
    int ln;
    exp_t e;
    @(negedge clk);
    base_val = b; imm_off = im; idx_val = ix; off_sel = os; shift_amt = sh;
    sub_off = sb_; addr_mode = md; size_byte = by; sign_ext = sg; req_valid = 1;
    off = (os == 0) ? AW'(im) : (os == 1) ? ix : (ix << sh);
    sum = sb_ ? b - off : b + off;
    acc = (md == 2) ? b : sum;
    w = mem_word({acc[AW-1:2], 2'b00});
    ln = exp_be ? 3 - int'(acc[1:0]) : int'(acc[1:0]);
    bt = w[8*ln +: 8];
    d = by ? (sg ? {{24{bt[7]}}, bt} : {24'd0, bt}) : w;
    e.data = d; e.wb = (md == 1 || md == 2); e.wbase = sum; e.tag = tag;
    sb.push_back(e);
    #1;
    chk(mem_rd_en === 1'b1, {tag, " R6 rd_en"}, AW'(mem_rd_en), 1);
    chk(mem_addr === {acc[AW-1:2], 2'b00}, {tag, " addr"}, mem_addr, {acc[AW-1:2], 2'b00});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  task automatic do_reset(bit be);
    @(negedge clk);
    req_valid = 0; rst_n = 0; big_endian_sel = be; exp_be = be;
    repeat (3) @(negedge clk);
    chk(result_valid === 1'b0 && wb_en === 1'b0, "R12 reset outputs",
        AW'({result_valid, wb_en}), 0);
    rst_n = 1;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(0);
    idle(2);
    load(32'h1000, 12'h014, 0, 0, 0, 0, 0, 0, 0, "R1 R4 imm word offset");
    load(32'h1000, 12'h013, 0, 0, 0, 0, 3, 1, 0, "R1 mode3 ubyte");
    load(32'h2000, 12'h008, 0, 0, 0, 1, 1, 0, 0, "R2 R5 pre sub word");
    load(32'h2001, 0, 32'h6, 1, 0, 0, 1, 1, 1, "R2 R4 R8 pre idx sbyte");
    load(32'h3002, 12'h040, 0, 0, 0, 0, 2, 1, 0, "R3 R7 post ubyte");
    load(32'h3003, 0, 32'h5, 2, 2, 1, 2, 1, 1, "R3 R4 R5 post shifted sub");
    idle(2);
    for (int k = 0; k < 4; k++) begin
      load(32'h40 + 32'(k), 0, 0, 0, 0, 0, 0, 1, 0, "R9 le ubyte lane");
      load(32'h80 + 32'(k), 0, 0, 0, 0, 0, 0, 1, 1, "R9 R8 le sbyte lane");
    end
    load(32'h123, 0, 32'h3, 3, 3, 0, 0, 0, 0, "R9 R4 word low bits ignored");
    load(32'h5000, 0, 32'h7, 3, 1, 0, 1, 0, 0, "R4 R2 shift1");
    big_endian_sel = 1;
    idle(2);
    load(32'h61, 0, 0, 0, 0, 0, 0, 1, 0, "R11 pin change ignored");
    load(32'h62, 0, 0, 0, 0, 0, 0, 1, 1, "R11 pin change ignored signed");
    idle(2);
    do_reset(1);
    @(negedge clk);
    big_endian_sel = 0;
    idle(1);
    for (int k = 0; k < 4; k++) begin
      load(32'h90 + 32'(k), 0, 0, 0, 0, 0, 0, 1, 0, "R10 be ubyte lane");
      load(32'hA0 + 32'(k), 12'h4, 0, 0, 0, 0, 1, 1, 1, "R10 R8 R2 be sbyte");
    end
    load(32'hB2, 0, 0, 0, 0, 0, 2, 0, 0, "R10 R3 be word");
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule